// File: doc/BRIEF.md
# Dynamic I2C Master Command Sequencer

This block sits between software and a byte-level I2C engine. Software pushes 10-bit command entries into a transmit command FIFO. Each entry holds a data byte, a flag asking for a start condition before the byte, and a flag asking for a stop condition once the byte or transfer is finished. The sequencer takes one entry at a time and turns it into engine requests: start, repeated start, byte write with an acknowledge result, byte read with a chosen ACK or NAK, and stop.

An entry with the start flag carries the address byte. When its direction bit selects a read, the next entry is a byte count. The sequencer reads that many bytes, NAKs the final one, and stops if the count entry asks for it. Received bytes go out on a separate receive interface, which can stall reception. If the slave NAKs, or arbitration is lost, the sequencer raises an event and throws away the rest of the failed command stream.

Four events let a controller pace its refills: the FIFO has drained, the FIFO has fallen to half depth, the bus has gone idle, and a transfer has erred or a read has completed.

Top module: `i2c_dyn_seq`

## Requirements
- R1: The command FIFO holds DEPTH (default 16, a power of two) entries of 10 bits. Bit 8 is the start flag, bit 9 is the stop flag and bits 7:0 are data. A push while `cmd_full` is high is ignored. `cmd_level` gives the occupancy.
- R2: While `enable` is low, no entry is taken from the FIFO and no new engine request begins.
- R3: A one-cycle `tx_flush` empties the FIFO by the next cycle. The flushed entries are never issued.
- R4: Engine op codes are 1 start, 2 repeated start, 3 write, 4 read and 5 stop. A start-flagged entry with no transfer open issues op 1, then op 3 with the entry's byte. Bits 7:1 of that byte are the address, and bit 0 is 1 for read and 0 for write.
- R5: A data entry inside an open transfer issues op 3 with its byte. If the entry carries the stop flag, op 5 follows.
- R6: After a read address, the next entry is a count N. The sequencer issues N reads with `eng_ack_send`=1 (ACK), except the last one, which has 0 (NAK). Each byte appears on `rx_push`/`rx_data` in the order it was read. `ev_tx_err` pulses once after the last byte. Op 5 follows only if the count entry has the stop flag. A count of 0 issues no reads.
- R7: A start-flagged entry arriving while a transfer is open, with no stop issued, issues op 2 instead of op 1.
- R8: A write address entry carrying both flags issues op 1, op 3 and op 5 only.
- R9: When `eng_nak` is reported on a write, `ev_tx_err` pulses and op 5 is issued. The FIFO entries up to and including the next stop-flagged entry are then discarded.
- R10: When `eng_arb_lost` is reported, `ev_arb_lost` pulses and no stop is issued. The entries up to and including the next stop-flagged entry are then discarded, and the next start uses op 1.
- R11: While `rx_full` is high, no read request is raised. Reception resumes after it clears, and no byte is lost.
- R12: `ev_tx_empty` pulses when the occupancy falls to zero. `ev_tx_half` pulses when it falls from above DEPTH/2 to DEPTH/2 or below.
- R13: A data entry without the start flag, arriving while no transfer is open, is dropped without any engine request.
- R14: `ev_bus_idle` pulses one cycle after `eng_bus_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows entries to be processed |
| tx_flush | input | 1 | Discards all queued entries |
| cmd_push | input | 1 | Write strobe for the command FIFO |
| cmd_data | input | 10 | {stop, start, byte} |
| cmd_full | output | 1 | FIFO is full |
| cmd_level | output | 5 | FIFO occupancy |
| eng_req | output | 1 | Request held until `eng_done` |
| eng_op | output | 3 | Requested operation |
| eng_wdata | output | 8 | Byte to write |
| eng_ack_send | output | 1 | 1 = ACK the read byte, 0 = NAK |
| eng_done | input | 1 | Operation finished (one cycle) |
| eng_nak | input | 1 | Written byte was NAKed (with done) |
| eng_arb_lost | input | 1 | Arbitration lost (with done) |
| eng_rdata | input | 8 | Byte read (with done) |
| eng_bus_busy | input | 1 | Bus is busy |
| rx_push | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| rx_full | input | 1 | Receive side cannot accept |
| ev_tx_empty | output | 1 | FIFO drained pulse |
| ev_tx_half | output | 1 | FIFO at half or below pulse |
| ev_tx_err | output | 1 | NAK or read-complete pulse |
| ev_arb_lost | output | 1 | Arbitration lost pulse |
| ev_bus_idle | output | 1 | Bus returned idle pulse |

## Verification
Some internal faults show up at the engine port on the very next request. A corrupted open-transfer flag appears as op 1 where op 2 was due, or the reverse. A wrong discard state shows up as a stray or missing request after a NAK or lost arbitration. A miscounted read length shows up within one byte of the end, as a NAK in the wrong position or a late `ev_tx_err`. The scoreboard therefore compares every engine request, with its data or ACK choice, and every received byte, in order. Event pulse counts and FIFO occupancy are checked once each scenario settles.

// File: rtl/i2c_dyn_seq.sv
module i2c_dyn_seq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     tx_flush,
  input  logic                     cmd_push,
  input  logic [DW+1:0]            cmd_data,
  output logic                     cmd_full,
  output logic [$clog2(DEPTH):0]   cmd_level,
  output logic                     eng_req,
  output logic [2:0]               eng_op,
  output logic [DW-1:0]            eng_wdata,
  output logic                     eng_ack_send,
  input  logic                     eng_done,
  input  logic                     eng_nak,
  input  logic                     eng_arb_lost,
  input  logic [DW-1:0]            eng_rdata,
  input  logic                     eng_bus_busy,
  output logic                     rx_push,
  output logic [DW-1:0]            rx_data,
  input  logic                     rx_full,
  output logic                     ev_tx_empty,
  output logic                     ev_tx_half,
  output logic                     ev_tx_err,
  output logic                     ev_arb_lost,
  output logic                     ev_bus_idle
);
  localparam int AW   = $clog2(DEPTH);
  localparam int EW   = DW + 2;
  localparam int HALF = DEPTH / 2;
  localparam logic [2:0] OP_START = 3'd1, OP_RESTART = 3'd2, OP_WRITE = 3'd3,
                         OP_READ  = 3'd4, OP_STOP    = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_COND, S_ADDR, S_CNT, S_RD, S_WR, S_STP} st_t;
  st_t st;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cnt_q;
  logic [EW-1:0] cur;
  logic [DW-1:0] rem;
  logic          open, skip, pend_stop, busy_q;

  wire [EW-1:0] head    = mem[rp];
  wire          empty   = (cnt == 0);
  wire          push_ok = cmd_push && !cmd_full && !tx_flush;
  wire          pop     = enable && !empty && !tx_flush && (st == S_IDLE || st == S_CNT);

  assign cmd_full     = (cnt == (AW+1)'(DEPTH));
  assign cmd_level    = cnt;
  assign eng_wdata    = cur[DW-1:0];
  assign eng_ack_send = (rem != DW'(1));
  assign ev_tx_empty  = (cnt_q != 0) && (cnt == 0);
  assign ev_tx_half   = (cnt_q > (AW+1)'(HALF)) && (cnt <= (AW+1)'(HALF));

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= cmd_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; cnt_q <= '0;
      busy_q <= 1'b0; ev_bus_idle <= 1'b0;
    end else begin
      cnt_q       <= cnt;
      busy_q      <= eng_bus_busy;
      ev_bus_idle <= busy_q && !eng_bus_busy;
      if (tx_flush) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push_ok) wp <= wp + 1'b1;
        if (pop)     rp <= rp + 1'b1;
        cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop);
      end
    end

  always_comb begin
    eng_req = 1'b1;
    eng_op  = OP_WRITE;
    case (st)
      S_COND:  eng_op = open ? OP_RESTART : OP_START;
      S_ADDR,
      S_WR:    eng_op = OP_WRITE;
      S_RD:    begin eng_op = OP_READ; eng_req = !rx_full; end
      S_STP:   eng_op = OP_STOP;
      default: eng_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; rem <= '0;
      open <= 1'b0; skip <= 1'b0; pend_stop <= 1'b0;
      ev_tx_err <= 1'b0; ev_arb_lost <= 1'b0;
      rx_push <= 1'b0; rx_data <= '0;
    end else begin
      ev_tx_err   <= 1'b0;
      ev_arb_lost <= 1'b0;
      rx_push     <= 1'b0;
      case (st)
        S_IDLE:
          if (pop) begin
            cur <= head;
            if (skip) begin
              if (head[DW+1]) skip <= 1'b0;
            end else st <= S_DEC;
          end
        S_DEC: begin
          pend_stop <= cur[DW+1];
          if (cur[DW])  st <= S_COND;
          else if (open) st <= S_WR;
          else           st <= S_IDLE;
        end
        S_COND:
          if (eng_done) begin
            if (eng_arb_lost) begin
              ev_arb_lost <= 1'b1; open <= 1'b0; skip <= !pend_stop; st <= S_IDLE;
            end else begin
              open <= 1'b1; st <= S_ADDR;
            end
          end
        S_ADDR, S_WR:
          if (eng_done) begin
            if (eng_arb_lost) begin
              ev_arb_lost <= 1'b1; open <= 1'b0; skip <= !pend_stop; st <= S_IDLE;
            end else if (eng_nak) begin
              ev_tx_err <= 1'b1; skip <= !pend_stop; st <= S_STP;
            end else if (st == S_ADDR && cur[0]) st <= S_CNT;
            else st <= cur[DW+1] ? S_STP : S_IDLE;
          end
        S_CNT:
          if (pop) begin
            rem       <= head[DW-1:0];
            pend_stop <= head[DW+1];
            if (head[DW-1:0] == '0) st <= head[DW+1] ? S_STP : S_IDLE;
            else                    st <= S_RD;
          end
        S_RD:
          if (eng_done) begin
            if (eng_arb_lost) begin
              ev_arb_lost <= 1'b1; open <= 1'b0; skip <= !pend_stop; st <= S_IDLE;
            end else begin
              rx_push <= 1'b1;
              rx_data <= eng_rdata;
              rem     <= rem - 1'b1;
              if (rem == DW'(1)) begin
                ev_tx_err <= 1'b1;
                st <= pend_stop ? S_STP : S_IDLE;
              end
            end
          end
        S_STP:
          if (eng_done) begin
            open <= 1'b0; st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/i2c_dyn_seq_chk.sv
module i2c_dyn_seq_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic                   tx_flush,
  input logic                   cmd_push,
  input logic                   cmd_full,
  input logic [$clog2(DEPTH):0] cmd_level,
  input logic                   eng_req,
  input logic [2:0]             eng_op,
  input logic                   eng_bus_busy,
  input logic                   rx_full,
  input logic                   ev_tx_empty,
  input logic                   ev_bus_idle
);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_level <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_full && cmd_push && !tx_flush && !enable |=> cmd_level == ($clog2(DEPTH)+1)'(DEPTH));

  a_r2_no_pop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !tx_flush |=> cmd_level >= $past(cmd_level));

  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> cmd_level == 0);

  a_r11_no_read_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !(eng_req && eng_op == 3'd4));

  a_r12_empty_event: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_empty |-> cmd_level == 0);

  a_r14_idle_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_idle |-> !$past(eng_bus_busy));
endmodule

bind i2c_dyn_seq i2c_dyn_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_flush(tx_flush),
  .cmd_push(cmd_push), .cmd_full(cmd_full), .cmd_level(cmd_level),
  .eng_req(eng_req), .eng_op(eng_op), .eng_bus_busy(eng_bus_busy),
  .rx_full(rx_full), .ev_tx_empty(ev_tx_empty), .ev_bus_idle(ev_bus_idle)
);

// File: tb/i2c_dyn_seq_test.sv
`timescale 1ns/1ps
module i2c_dyn_seq_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, tx_flush = 1'b0, cmd_push = 1'b0;
  logic [9:0] cmd_data = '0;
  logic cmd_full; logic [4:0] cmd_level;
  logic eng_req, eng_ack_send; logic [2:0] eng_op; logic [7:0] eng_wdata;
  logic eng_done = 1'b0, eng_nak = 1'b0, eng_arb_lost = 1'b0, eng_bus_busy = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic rx_push; logic [7:0] rx_data; logic rx_full = 1'b0;
  logic ev_tx_empty, ev_tx_half, ev_tx_err, ev_arb_lost, ev_bus_idle;

  i2c_dyn_seq uut (.*);

  int n_tests = 0, n_fail = 0;
  int n_err = 0, n_arb = 0, n_emp = 0, n_half = 0, n_idle = 0, n_ops = 0, n_rx = 0;
  bit done_flag = 0;
  logic [10:0] exp_q[$];
  string       exp_tag[$];
  logic [7:0]  rx_exp[$];
  logic [7:0]  nak_byte = 8'hFF, rd_seed = 8'h40;
  bit          arb_next = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push_exp(input logic [2:0] op, input logic [7:0] d, input string tag);
    exp_q.push_back({op, d});
    exp_tag.push_back(tag);
  endtask

  task automatic cmd(input bit s, input bit p, input logic [7:0] b);
    cmd_data = {p, s, b};
    cmd_push = 1'b1;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    bit dp;
    logic [10:0] got, e;
    string t;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (ev_tx_err)   n_err++;
      if (ev_arb_lost) n_arb++;
      if (ev_tx_empty) n_emp++;
      if (ev_tx_half)  n_half++;
      if (ev_bus_idle) n_idle++;
      if (rx_push) begin
        n_rx++;
        if (rx_exp.size() == 0) check(0, "R6 unexpected rx byte", rx_data, 0);
        else begin
          e[7:0] = rx_exp.pop_front();
          check(rx_data == e[7:0], "R6 rx byte order", rx_data, e[7:0]);
        end
      end
      dp = eng_done;
      eng_done = 0; eng_nak = 0; eng_arb_lost = 0;
      if (eng_req && !dp) begin
        n_ops++;
        got = {eng_op, (eng_op == 3'd4) ? {7'b0, eng_ack_send} :
                       (eng_op == 3'd3) ? eng_wdata : 8'h00};
        if (exp_q.size() == 0) check(0, "R13 unexpected engine request", got, 0);
        else begin
          e = exp_q.pop_front(); t = exp_tag.pop_front();
          check(got == e, t, got, e);
        end
        eng_done = 1;
        case (eng_op)
          3'd1, 3'd2: if (arb_next) begin eng_arb_lost = 1; arb_next = 0; end
                      else eng_bus_busy = 1;
          3'd3: eng_nak = (eng_wdata == nak_byte);
          3'd4: begin eng_rdata = rd_seed; rx_exp.push_back(rd_seed); rd_seed++; end
          3'd5: eng_bus_busy = 0;
          default: ;
        endcase
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int b_err, b_half, b_emp, b_ops, b_rx;
    repeat (3) @(negedge clk);
    check(cmd_level == 0 && !eng_req && !rx_push, "R1 reset state", {cmd_level, eng_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;

    push_exp(1, 8'h00, "R4 start"); push_exp(3, 8'hA0, "R4 address");
    push_exp(3, 8'hA1, "R5 data"); push_exp(3, 8'hA2, "R5 data last");
    push_exp(5, 8'h00, "R5 stop");
    cmd(1, 0, 8'hA0); cmd(0, 0, 8'hA1); cmd(0, 1, 8'hA2);
    settle();
    check(n_idle == 1, "R14 bus idle event", n_idle, 1);
    check(n_err == 0, "R5 no error on acked write", n_err, 0);
    check(cmd_level == 0, "R1 level drained", cmd_level, 0);

    b_rx = n_rx;
    push_exp(1, 0, "R6 start"); push_exp(3, 8'hA3, "R6 read address");
    push_exp(4, 1, "R6 ack 1"); push_exp(4, 1, "R6 ack 2"); push_exp(4, 0, "R6 nak last");
    push_exp(5, 0, "R6 stop");
    cmd(1, 0, 8'hA3); cmd(0, 1, 8'd3);
    settle();
    check(n_rx - b_rx == 3, "R6 byte count", n_rx - b_rx, 3);
    check(n_err == 1, "R6 completion error pulse", n_err, 1);

    push_exp(1, 0, "R7 first start"); push_exp(3, 8'hA0, "R7 address");
    push_exp(3, 8'h10, "R7 data"); push_exp(2, 0, "R7 repeated start");
    push_exp(3, 8'hA3, "R7 read address"); push_exp(4, 0, "R6 single byte nak");
    push_exp(5, 0, "R7 stop");
    cmd(1, 0, 8'hA0); cmd(0, 0, 8'h10); cmd(1, 0, 8'hA3); cmd(0, 1, 8'd1);
    settle();
    check(n_err == 2, "R6 single read error pulse", n_err, 2);

    b_ops = n_ops;
    push_exp(1, 0, "R8 start"); push_exp(3, 8'hA0, "R8 address"); push_exp(5, 0, "R8 stop");
    cmd(1, 1, 8'hA0);
    settle();
    check(n_ops - b_ops == 3, "R8 address-only op count", n_ops - b_ops, 3);

    nak_byte = 8'h90;
    push_exp(1, 0, "R9 start"); push_exp(3, 8'h90, "R9 nak address"); push_exp(5, 0, "R9 stop");
    push_exp(1, 0, "R9 next start"); push_exp(3, 8'hA0, "R9 next address"); push_exp(5, 0, "R9 next stop");
    cmd(1, 0, 8'h90); cmd(0, 0, 8'h11); cmd(0, 1, 8'h12); cmd(1, 1, 8'hA0);
    settle();
    check(n_err == 3, "R9 nak error pulse", n_err, 3);
    check(cmd_level == 0, "R9 discarded entries", cmd_level, 0);
    nak_byte = 8'hFF;

    arb_next = 1;
    push_exp(1, 0, "R10 lost start");
    push_exp(1, 0, "R10 fresh start"); push_exp(3, 8'hA4, "R10 address"); push_exp(5, 0, "R10 stop");
    cmd(1, 0, 8'hA0); cmd(0, 1, 8'h33); cmd(1, 1, 8'hA4);
    settle();
    check(n_arb == 1, "R10 arbitration event", n_arb, 1);

    enable = 1'b0;
    cmd(1, 1, 8'hA6);
    repeat (20) @(negedge clk);
    check(cmd_level == 1, "R2 held while disabled", cmd_level, 1);
    check(!eng_req, "R2 no request while disabled", eng_req, 0);
    push_exp(1, 0, "R2 start"); push_exp(3, 8'hA6, "R2 address"); push_exp(5, 0, "R2 stop");
    enable = 1'b1;
    settle();

    enable = 1'b0; b_ops = n_ops;
    cmd(1, 0, 8'hA0); cmd(0, 0, 8'h01); cmd(0, 1, 8'h02);
    check(cmd_level == 3, "R3 level before flush", cmd_level, 3);
    tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
    check(cmd_level == 0, "R3 flushed", cmd_level, 0);
    enable = 1'b1;
    repeat (20) @(negedge clk);
    check(n_ops == b_ops, "R3 flushed entries not issued", n_ops - b_ops, 0);

    rx_full = 1'b1; b_err = n_err;
    push_exp(1, 0, "R11 start"); push_exp(3, 8'hA3, "R11 address");
    cmd(1, 0, 8'hA3); cmd(0, 1, 8'd2);
    settle();
    repeat (20) @(negedge clk);
    check(!eng_req, "R11 read stalled", eng_req, 0);
    push_exp(4, 1, "R11 ack"); push_exp(4, 0, "R11 nak"); push_exp(5, 0, "R11 stop");
    rx_full = 1'b0;
    settle();
    check(n_err - b_err == 1, "R11 read completed", n_err - b_err, 1);
    check(rx_exp.size() == 0, "R11 no byte lost", rx_exp.size(), 0);

    enable = 1'b0; b_half = n_half; b_emp = n_emp; b_ops = n_ops;
    for (int i = 0; i < 16; i++) cmd(0, 0, 8'(i));
    check(cmd_full && cmd_level == 16, "R1 full at depth", cmd_level, 16);
    cmd(0, 0, 8'h77);
    check(cmd_level == 16, "R1 push ignored when full", cmd_level, 16);
    enable = 1'b1;
    repeat (60) @(negedge clk);
    check(cmd_level == 0, "R13 orphan data drained", cmd_level, 0);
    check(n_ops == b_ops, "R13 orphan data no request", n_ops - b_ops, 0);
    check(n_half - b_half == 1, "R12 half event", n_half - b_half, 1);
    check(n_emp - b_emp == 1, "R12 empty event", n_emp - b_emp, 1);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule